// File: doc/BRIEF.md
# AES Round-Key Schedule Generator

This block turns an AES cipher key of 128, 192 or 256 bits into its round-key schedule, one 32-bit word per clock. A word window holds the last Nk words. Each new word is formed with a byte rotation, a byte substitution and a round constant. Every four words are joined into one 128-bit round key. The substitution table is computed in logic rather than stored.

The block has two operating modes, and both are picked when `load` is sampled. In forward mode (`pre_mode` = 0) the block makes one round key, presents it with `rk_valid`, and waits for the cipher to take it with `next_req` before it makes the next one. The whole schedule is never held. In pre-expansion mode (`pre_mode` = 1) the block runs without stopping and writes every round key into an external key memory. The write address is the round index. A decryptor can then read the schedule back in reverse order. A design that already holds an expanded key can leave this block out.

The control state machine has four states:
- `S_IDLE` is left only by `load`.
- `S_FILL` makes one word per cycle.
  - After the fourth word it moves to `S_HOLD` in forward mode.
  - In pre-expansion mode it stays in `S_FILL`, or moves to `S_DONE` after the last key.
- `S_HOLD` moves to `S_FILL` on `next_req`, or to `S_DONE` if the last key was being presented.
- `S_DONE` waits for `load`.
- `load` moves any state to `S_FILL`.

Top module: `aes_key_expander`

## Requirements
- R1: `key_size` selects the key length: 00 is 128 bits, 01 is 192 bits, 10 is 256 bits, and the reserved code 11 behaves as 00. The key is taken from the most significant bits of `key_in`, and the low bits that the selected length does not use have no effect.
- R2: The schedule has 11, 13 or 15 round keys for 128, 192 or 256 bits, and the values follow standard AES key expansion. The first word of each round key sits in bits [127:96].
- R3: A `load` sampled at a rising edge abandons any operation and restarts at round key 0, even if `next_req` is high in the same cycle. After that edge, `rk_valid`, `mem_we` and `done` are low. The key, size code and mode are captured at that edge, and later changes to those inputs have no effect.
- R4: In forward mode, `rk_valid` goes high on the fourth rising edge after the edge that samples `load`. `mem_addr` then holds the index of the key shown on `rk_out`.
- R5: While `rk_valid` is high and neither `next_req` nor `load` is sampled, `rk_out`, `mem_addr` and `rk_valid` stay unchanged. When `next_req` is sampled, `rk_valid` drops, and the next key is valid on the fourth edge after that one.
- R6: `next_req` has no effect unless `rk_valid` is high.
- R7: In forward mode, taking the last key with `next_req` leaves `rk_valid` low and raises `done`.
- R8: In pre-expansion mode:
  - `mem_we` pulses for one cycle every four cycles.
  - `mem_addr` counts 0, 1, 2, … upward.
  - `mem_wdata` carries the key for that index.
  - `rk_valid` stays low.
  - `next_req` is ignored.
- R9: In pre-expansion mode, `done` rises with the last write. In either mode, `done` stays high until the next `load`.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| key_in | input | KEY_W (256) | Cipher key, left-aligned |
| key_size | input | 2 | Key-length code, captured at load |
| pre_mode | input | 1 | 0 = forward on demand, 1 = pre-expand to memory |
| load | input | 1 | Start a new schedule at round key 0 |
| next_req | input | 1 | Cipher has taken the presented key |
| rk_out | output | RK_W (128) | Presented round key |
| rk_valid | output | 1 | rk_out holds a key for the cipher |
| mem_we | output | 1 | Key-memory write strobe |
| mem_addr | output | IDX_W (4) | Round index of the current key |
| mem_wdata | output | RK_W (128) | Key-memory write data |
| done | output | 1 | Schedule complete |

## Verification
The assertions take for granted the following about the inputs:
- `rst_n` is asserted before the first `load`.
- `next_req` and `load` are single-cycle pulses.
- `key_in`, `key_size` and `pre_mode` matter only in the cycle that `load` is sampled.

The stimulus drives every input on the falling edge. It changes key, size and mode right after each load to show they were captured. It sends stray `next_req` pulses while a key is being built and during pre-expansion. It also includes a restart in the middle of a schedule and a restart that coincides with `next_req`.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_HOLD = 2'd2,
        S_DONE = 2'd3
    } kx_state_e;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p = p ^ x;
            x = gf_xtime(x);
        end
        return p;
    endfunction

    // multiplicative inverse as a^254, then the affine map
    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = a;
        inv = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [31:0] sub_word(input logic [31:0] w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    // words per key for a size code (11 treated as 128-bit)
    function automatic logic [3:0] nk_of(input logic [1:0] sz);
        case (sz)
            2'b01:   return 4'd6;
            2'b10:   return 4'd8;
            default: return 4'd4;
        endcase
    endfunction

    // round keys in the schedule for a size code
    function automatic logic [3:0] nkeys_of(input logic [1:0] sz);
        case (sz)
            2'b01:   return 4'd13;
            2'b10:   return 4'd15;
            default: return 4'd11;
        endcase
    endfunction

endpackage

// File: rtl/aes_kx_word.sv
module aes_kx_word #(
    parameter int KEY_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             gen_en,
    input  logic [KEY_W-1:0] key_in,
    input  logic [1:0]       key_size,
    output logic [31:0]      word_out
);
    import aes_kx_pkg::*;

    localparam int WORD_W = 32;
    localparam int WIN    = KEY_W / WORD_W;
    localparam int PW     = $clog2(WIN + 1);
    localparam int IW     = $clog2(WIN);

    logic [WORD_W-1:0] win_q [WIN];
    logic [KEY_W-1:0]  key_q;
    logic [PW-1:0]     left_q, kpos_q, nk_q;
    logic [7:0]        rcon_q;

    logic [IW-1:0]     back_sel;
    logic [WORD_W-1:0] prev_w, sw_in, sw_out, temp_w;

    assign back_sel = IW'(nk_q - PW'(1));
    assign prev_w   = win_q[0];
    assign sw_in    = (kpos_q == '0) ? {prev_w[23:0], prev_w[31:24]} : prev_w;
    assign sw_out   = sub_word(sw_in);

    always_comb begin
        if (kpos_q == '0)
            temp_w = sw_out ^ {rcon_q, 24'h0};
        else if (nk_q == PW'(8) && kpos_q == PW'(4))
            temp_w = sw_out;
        else
            temp_w = prev_w;
        word_out = (left_q != '0) ? key_q[KEY_W-1 -: WORD_W] : (win_q[back_sel] ^ temp_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            left_q <= '0;
            kpos_q <= '0;
            nk_q   <= PW'(4);
            rcon_q <= 8'h01;
            for (int j = 0; j < WIN; j++) win_q[j] <= '0;
        end else if (load) begin
            key_q  <= key_in;
            left_q <= PW'(nk_of(key_size));
            nk_q   <= PW'(nk_of(key_size));
            kpos_q <= '0;
            rcon_q <= 8'h01;
            for (int j = 0; j < WIN; j++) win_q[j] <= '0;
        end else if (gen_en) begin
            for (int j = WIN - 1; j > 0; j--) win_q[j] <= win_q[j-1];
            win_q[0] <= word_out;
            key_q    <= key_q << WORD_W;
            if (left_q != '0) left_q <= left_q - PW'(1);
            kpos_q <= (kpos_q == nk_q - PW'(1)) ? '0 : kpos_q + PW'(1);
            if (left_q == '0 && kpos_q == '0) rcon_q <= gf_xtime(rcon_q);
        end
    end

endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl #(
    parameter int IDX_W = 4,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             next_req,
    input  logic             pre_mode,
    input  logic [1:0]       key_size,
    output logic             gen_en,
    output logic             key_done,
    output logic             rk_valid,
    output logic             mem_we,
    output logic             done,
    output logic [IDX_W-1:0] idx_out
);
    import aes_kx_pkg::*;

    kx_state_e        state_q, state_d;
    logic             mode_q;
    logic [IDX_W-1:0] nkeys_q, kidx_q;
    logic [SW-1:0]    wsel_q;
    logic             last_key, take;

    assign gen_en   = (state_q == S_FILL);
    assign key_done = gen_en && (wsel_q == {SW{1'b1}});
    assign last_key = (kidx_q == nkeys_q - IDX_W'(1));
    assign take     = (state_q == S_HOLD) && next_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = S_IDLE;
            S_FILL: if (key_done) state_d = !mode_q ? S_HOLD : (last_key ? S_DONE : S_FILL);
            S_HOLD: if (next_req) state_d = last_key ? S_DONE : S_FILL;
            S_DONE: state_d = S_DONE;
        endcase
        if (load) state_d = S_FILL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= 1'b0;
            nkeys_q <= IDX_W'(11);
            kidx_q  <= '0;
            wsel_q  <= '0;
        end else if (load) begin
            state_q <= state_d;
            mode_q  <= pre_mode;
            nkeys_q <= IDX_W'(nkeys_of(key_size));
            kidx_q  <= '0;
            wsel_q  <= '0;
        end else begin
            state_q <= state_d;
            if (gen_en) wsel_q <= wsel_q + SW'(1);
            if ((key_done && mode_q && !last_key) || (take && !last_key))
                kidx_q <= kidx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rk_valid <= 1'b0;
            mem_we   <= 1'b0;
            done     <= 1'b0;
            idx_out  <= '0;
        end else if (load) begin
            rk_valid <= 1'b0;
            mem_we   <= 1'b0;
            done     <= 1'b0;
            idx_out  <= '0;
        end else begin
            mem_we <= key_done && mode_q;
            if (key_done) idx_out <= kidx_q;
            if (key_done && !mode_q) rk_valid <= 1'b1;
            if (take) rk_valid <= 1'b0;
            if ((key_done && mode_q && last_key) || (take && last_key)) done <= 1'b1;
        end
    end

endmodule

// File: rtl/aes_key_expander.sv
module aes_key_expander #(
    parameter int KEY_W = 256,
    parameter int RK_W  = 128,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_in,
    input  logic [1:0]       key_size,
    input  logic             pre_mode,
    input  logic             load,
    input  logic             next_req,
    output logic [RK_W-1:0]  rk_out,
    output logic             rk_valid,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output logic [RK_W-1:0]  mem_wdata,
    output logic             done
);
    localparam int WORD_W = 32;
    localparam int WPK    = RK_W / WORD_W;
    localparam int SW     = $clog2(WPK);

    logic              gen_en, key_done;
    logic [WORD_W-1:0] word;
    logic [RK_W-WORD_W-1:0] part_q;
    logic [RK_W-1:0]   rk_q;

    aes_kx_word #(.KEY_W(KEY_W)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .gen_en   (gen_en),
        .key_in   (key_in),
        .key_size (key_size),
        .word_out (word)
    );

    aes_kx_ctrl #(.IDX_W(IDX_W), .SW(SW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .next_req (next_req),
        .pre_mode (pre_mode),
        .key_size (key_size),
        .gen_en   (gen_en),
        .key_done (key_done),
        .rk_valid (rk_valid),
        .mem_we   (mem_we),
        .done     (done),
        .idx_out  (mem_addr)
    );

    generate
        if (WPK > 2) begin : g_shift_wide
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      part_q <= '0;
                else if (gen_en) part_q <= {part_q[RK_W-2*WORD_W-1:0], word};
            end
        end else begin : g_shift_narrow
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      part_q <= '0;
                else if (gen_en) part_q <= word;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rk_q <= '0;
        else if (key_done) rk_q <= {part_q, word};
    end

    assign rk_out    = rk_q;
    assign mem_wdata = rk_q;

endmodule

// File: rtl/aes_kx_checker.sv
module aes_kx_checker #(
    parameter int RK_W  = 128,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             next_req,
    input logic [RK_W-1:0]  rk_out,
    input logic             rk_valid,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_addr,
    input logic             done
);
    logic [IDX_W-1:0] want_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      want_addr_q <= '0;
        else if (load)   want_addr_q <= '0;
        else if (mem_we) want_addr_q <= mem_addr + IDX_W'(1);
    end

    p_load_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!rk_valid && !mem_we && !done));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid && !next_req && !load) |=> (rk_valid && $stable(rk_out) && $stable(mem_addr)));

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rk_valid);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rk_valid, mem_we}));

    p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_addr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == want_addr_q));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

bind aes_key_expander aes_kx_checker #(.RK_W(RK_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .next_req (next_req),
    .rk_out   (rk_out),
    .rk_valid (rk_valid),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/aes_key_expander_bench.sv
module aes_key_expander_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] key_in;
    logic [1:0]   key_size;
    logic         pre_mode, load, next_req;
    logic [127:0] rk_out, mem_wdata;
    logic         rk_valid, mem_we, done;
    logic [3:0]   mem_addr;

    aes_key_expander u_aes_key_expander (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_size(key_size),
        .pre_mode(pre_mode), .load(load), .next_req(next_req),
        .rk_out(rk_out), .rk_valid(rk_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0, n_err = 0, cyc = 0;
    bit    run_cmp = 0;
    string phase_tag = "R10";

    // ---------------- independent AES schedule ----------------
    logic [7:0]   exp_t [256];
    int           log_t [256];
    logic [127:0] exp_rk [15];

    function automatic logic [7:0] xt(input logic [7:0] a);
        return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
    endfunction

    initial begin
        logic [7:0] x;
        x = 8'h01;
        for (int k = 0; k < 255; k++) begin
            exp_t[k] = x;
            log_t[x] = k;
            x = x ^ xt(x);
        end
    end

    function automatic logic [7:0] bsbox(input logic [7:0] a);
        logic [7:0] inv, r, c;
        inv = (a == 0) ? 8'h00 : exp_t[(255 - log_t[a]) % 255];
        c = 8'h63;
        for (int b = 0; b < 8; b++)
            r[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8] ^ c[b];
        return r;
    endfunction

    function automatic logic [31:0] bsubw(input logic [31:0] w);
        return {bsbox(w[31:24]), bsbox(w[23:16]), bsbox(w[15:8]), bsbox(w[7:0])};
    endfunction

    function automatic void expand(input logic [255:0] k, input logic [1:0] sz);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0]  rc;
        int nk, nr;
        nk = (sz == 2'b01) ? 6 : (sz == 2'b10) ? 8 : 4;
        nr = nk + 6;
        rc = 8'h01;
        for (int i = 0; i < nk; i++) w[i] = k[255 - 32*i -: 32];
        for (int i = nk; i < 4*(nr+1); i++) begin
            t = w[i-1];
            if (i % nk == 0) begin
                t = bsubw({t[23:0], t[31:24]});
                t[31:24] = t[31:24] ^ rc;
                rc = xt(rc);
            end else if (nk == 8 && i % nk == 4) begin
                t = bsubw(t);
            end
            w[i] = w[i-nk] ^ t;
        end
        for (int r = 0; r <= nr; r++)
            exp_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endfunction

    // ---------------- cycle model ----------------
    int m_ph = 0, m_cnt = 0, m_k = 0, m_n = 11, m_idx = 0;
    bit m_mode = 0, m_valid = 0, m_we = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_valid = 0; m_we = 0; m_done = 0; m_idx = 0;
        end else if (load) begin
            expand(key_in, key_size);
            m_n = (key_size == 2'b01) ? 13 : (key_size == 2'b10) ? 15 : 11;
            m_ph = 1; m_cnt = 0; m_k = 0; m_idx = 0; m_mode = pre_mode;
            m_valid = 0; m_we = 0; m_done = 0;
        end else begin
            m_we = 0;
            if (m_ph == 1) begin
                m_cnt++;
                if (m_cnt == 4) begin
                    m_cnt = 0;
                    m_idx = m_k;
                    if (!m_mode) begin
                        m_valid = 1; m_ph = 2;
                    end else begin
                        m_we = 1;
                        if (m_k == m_n - 1) begin m_done = 1; m_ph = 3; end
                        else m_k++;
                    end
                end
            end else if (m_ph == 2 && next_req) begin
                m_valid = 0;
                if (m_k == m_n - 1) begin m_done = 1; m_ph = 3; end
                else begin m_k++; m_ph = 1; m_cnt = 0; end
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, phase_tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R4 rk_valid", 128'(rk_valid), 128'(m_valid));
            chk("R8 mem_we", 128'(mem_we), 128'(m_we));
            chk("R9 done", 128'(done), 128'(m_done));
            if (m_valid) begin
                chk("R2 rk_out", rk_out, exp_rk[m_idx]);
                chk("R5 index", 128'(mem_addr), 128'(m_idx));
            end
            if (m_we) begin
                chk("R2 mem_wdata", mem_wdata, exp_rk[m_idx]);
                chk("R8 mem_addr", 128'(mem_addr), 128'(m_idx));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R4 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_load(input bit pm, input logic [1:0] sz, input logic [255:0] k, input bit with_req);
        @(negedge clk);
        load = 1; pre_mode = pm; key_size = sz; key_in = k; next_req = with_req;
        @(negedge clk);
        load = 0; next_req = 0;
        key_in = ~k; key_size = ~sz; pre_mode = ~pm;   // R3: captured at load
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!rk_valid);
    endtask

    task automatic run_fwd(input int n, input bit fips);
        for (int k = 0; k < n; k++) begin
            wait_valid();
            chk("R6 index after ignored request", 128'(mem_addr), 128'(k));
            if (fips && k == 1)
                chk("R2 known round key 1", rk_out, 128'ha0fafe1788542cb123a339392a6c7605);
            if (fips && k == 10)
                chk("R2 known round key 10", rk_out, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
            repeat (k % 3) @(negedge clk);
            next_req = 1;
            @(negedge clk);
            next_req = 1;               // R6: stray pulse while not valid
            @(negedge clk);
            next_req = 0;
        end
        @(negedge clk);
        chk("R7 done after last key", 128'(done), 128'(1));
        chk("R7 rk_valid low at end", 128'(rk_valid), 128'(0));
    endtask

    task automatic run_pre(input int n);
        int  nw = 0, c = 0;
        bit  fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (mem_we) nw++;
            if (done) fin = 1;
            next_req = (c % 5 == 2);    // R8: ignored in pre-expansion
            c++;
        end
        next_req = 0;
        chk("R8 write count", 128'(nw), 128'(n));
        chk("R9 done held", 128'(done), 128'(1));
    endtask

    localparam logic [127:0] FIPS_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

    initial begin
        rst_n = 0; key_in = '0; key_size = 2'b00; pre_mode = 0; load = 0; next_req = 0;
        repeat (3) @(negedge clk);
        phase_tag = "R10";
        chk("R10 flags in reset", 128'({rk_valid, mem_we, done}), 128'(0));
        chk("R10 rk_out in reset", rk_out, 128'(0));
        chk("R10 mem_addr in reset", 128'(mem_addr), 128'(0));
        rst_n = 1;
        run_cmp = 1;

        phase_tag = "R1 fwd128 with junk low bits";
        do_load(0, 2'b00, {FIPS_KEY, 128'hdeadbeef_0badf00d_12345678_9abcdef0}, 0);
        run_fwd(11, 1);

        phase_tag = "R8 pre192";
        do_load(1, 2'b01, 256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b_0000000000000000, 0);
        run_pre(13);

        phase_tag = "R9 pre256";
        do_load(1, 2'b10, 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4, 0);
        run_pre(15);

        phase_tag = "R3 restart with next_req";
        do_load(0, 2'b10, 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 0);
        wait_valid();
        next_req = 1; @(negedge clk); next_req = 0;
        wait_valid();
        do_load(1, 2'b01, 256'hffeeddccbbaa99887766554433221100a5a5a5a55a5a5a5a_0f0f0f0f0f0f0f0f, 1);
        run_pre(13);

        phase_tag = "R1 reserved size code";
        do_load(0, 2'b11, 256'h00112233445566778899aabbccddeeff_ffffffffffffffffffffffffffffffff, 0);
        wait_valid();
        chk("R1 code 11 key 0 is upper 128 bits", rk_out, 128'h00112233445566778899aabbccddeeff);
        run_fwd(11, 0);

        phase_tag = "R5 fwd192";
        do_load(0, 2'b01, 256'h1032547698badcfe0123456789abcdef5566778899aabbcc_1111111111111111, 0);
        run_fwd(13, 0);

        phase_tag = "R3 restart mid pre-expansion";
        do_load(1, 2'b10, 256'hcafebabe_deadbeef_01234567_89abcdef_fedcba98_76543210_13579bdf_2468ace0, 0);
        repeat (9) @(negedge clk);
        do_load(0, 2'b00, {FIPS_KEY, 128'h0}, 0);
        wait_valid();
        chk("R3 restart begins at key 0", 128'(mem_addr), 128'(0));
        chk("R3 restart key 0 value", rk_out, FIPS_KEY);
        run_fwd(11, 1);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule